// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer with Reset Pulse

This block is a recovery timer for a small processor core. It sits on the core's special-function-register write bus and starts out dormant. Software wakes it by writing the byte 1EH and then the byte E1H to one service address. From then on a 14-bit count advances once per machine cycle. Software must repeat the same two-byte key before the count reaches its top value. If it does not, the block drives a reset pulse of fixed length and returns to the dormant state.

Software has no way to read or write the count, and no write can stop the timer once it runs. Only the external reset or the timer's own overflow returns it to the dormant state. The length of the reset pulse is counted in oscillator clocks. It is 98 clocks when the core runs six clocks per machine cycle and 196 clocks when it runs twelve.

Top module: `wdog_top`

## Requirements
- R1: While the asynchronous active-low reset `rstN` is low, and afterwards until the key sequence has been written, `rstOut` is low and the timer is dormant.
- R2: A write of 1EH to address A6H, followed by a write of E1H to address A6H, starts the timer. Writes to any other address are ignored and do not break the sequence. Once running, no write stops the timer.
- R3: E1H completes the key only when the previous write to A6H was 1EH. Any other value written to A6H clears the half-entered key. A repeated 1EH leaves the key half-entered.
- R4: While running, the count advances only on clock edges where `mcStrobe` is high. `rstOut` rises on the clock edge after the count has held 3FFFH for a cycle. When the strobe is held high, that is the 16384th edge after the edge that started the timer.
- R5: A completed key while running returns the count to zero. If the key completes on the same edge as a strobe, the clear takes priority over the increment.
- R6: When the key completes on the very edge at which the count already holds 3FFFH, the overflow wins and the reset pulse is still issued.
- R7: The reset pulse is high for exactly 98 clock cycles when `modeSix` is 1 and for 196 cycles when `modeSix` is 0. The mode is taken at the moment of overflow.
- R8: An overflow stops the timer and clears the half-entered key. Key writes made during the pulse are ignored, and after the pulse the timer stays dormant.
- R9: Asserting `rstN` forces `rstOut` low at once, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low external reset |
| mcStrobe | input | 1 | One-clock strobe per machine cycle |
| modeSix | input | 1 | 1: six clocks per machine cycle, 0: twelve |
| sfrWrEn | input | 1 | SFR write strobe |
| sfrAddr | input | 8 | SFR write address |
| sfrData | input | 8 | SFR write data |
| rstOut | output | 1 | Reset pulse, active high |

## Verification
The two events that can fall on the same edge are completion of the service key and overflow of the count. The bench lands the E1H write exactly on the edge at which the count holds 3FFFH. It also lands it one edge earlier, when the count holds 3FFEH and a strobe is present. In the first case `rstOut` must be high right after the write and the pulse must have full length. In the second case no pulse may appear until a further 16384 edges have passed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic pulseLoad;
    logic pulseLong;
    logic pulseDec;
  } wdogCmdT;

  // flags from datapath back to control
  typedef struct packed {
    logic cntAtMax;
    logic pulseLast;
  } wdogStatT;

endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 'hE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              keyDone
);

  logic armedQ;
  logic svcHit;

  assign svcHit  = wrEn && (wrAddr == SVC_ADDR);
  assign keyDone = svcHit && !flush && armedQ && (wrData == KEY_B);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       armedQ <= 1'b0;
    else if (flush)  armedQ <= 1'b0;
    else if (svcHit) armedQ <= (wrData == KEY_A);
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     mcStrobe,
  input  logic     modeSix,
  input  logic     keyDone,
  input  wdogStatT stat,
  output wdogCmdT  cmd,
  output logic     flush,
  output logic     enabled,
  output logic     rstOut
);

  logic enabledQ;
  logic pulseQ;
  logic ovf;

  assign ovf   = enabledQ && stat.cntAtMax;
  assign flush = pulseQ || ovf;

  always_comb begin
    cmd.cntClr    = ovf || keyDone || !enabledQ;
    cmd.cntInc    = enabledQ && mcStrobe;
    cmd.pulseLoad = ovf;
    cmd.pulseLong = !modeSix;
    cmd.pulseDec  = pulseQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabledQ <= 1'b0;
      pulseQ   <= 1'b0;
    end else if (ovf) begin
      enabledQ <= 1'b0;
      pulseQ   <= 1'b1;
    end else begin
      if (pulseQ && stat.pulseLast) pulseQ <= 1'b0;
      if (keyDone) enabledQ <= 1'b1;
    end
  end

  assign enabled = enabledQ;
  assign rstOut  = pulseQ;

endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int PULSE_SHORT = 98,
  parameter int PULSE_LONG = 196
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdogCmdT          cmd,
  output wdogStatT         stat,
  output logic [CNT_W-1:0] cntVal
);

  localparam int PW = $clog2(PULSE_LONG);

  logic [CNT_W-1:0] cntQ;
  logic [PW-1:0]    pulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cntQ <= '0;
    else if (cmd.cntClr) cntQ <= '0;
    else if (cmd.cntInc) cntQ <= cntQ + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              pulseQ <= '0;
    else if (cmd.pulseLoad)                 pulseQ <= cmd.pulseLong ? PW'(PULSE_LONG - 1) : PW'(PULSE_SHORT - 1);
    else if (cmd.pulseDec && pulseQ != '0)  pulseQ <= pulseQ - PW'(1);
  end

  assign stat.cntAtMax  = (cntQ == '1);
  assign stat.pulseLast = (pulseQ == '0);
  assign cntVal         = cntQ;

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 'hE1,
  parameter int PULSE_SHORT = 98,
  parameter int PULSE_LONG = 196
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcStrobe,
  input  logic              modeSix,
  input  logic              sfrWrEn,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [DATA_W-1:0] sfrData,
  output logic              rstOut
);

  wdogCmdT          cmd;
  wdogStatT         stat;
  logic             keyDone;
  logic             flush;
  logic             enabled;
  logic             cntAtMax;
  logic [CNT_W-1:0] cntVal;

  wdog_keyseq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_keyseq (
    .clk(clk), .rstN(rstN), .flush(flush), .wrEn(sfrWrEn),
    .wrAddr(sfrAddr), .wrData(sfrData), .keyDone(keyDone)
  );

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .modeSix(modeSix),
    .keyDone(keyDone), .stat(stat), .cmd(cmd), .flush(flush),
    .enabled(enabled), .rstOut(rstOut)
  );

  wdog_dp #(
    .CNT_W(CNT_W), .PULSE_SHORT(PULSE_SHORT), .PULSE_LONG(PULSE_LONG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stat(stat), .cntVal(cntVal)
  );

  assign cntAtMax = stat.cntAtMax;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 14,
  parameter int PULSE_SHORT = 98,
  parameter int PULSE_LONG = 196
) (
  input logic             clk,
  input logic             rstN,
  input logic             mcStrobe,
  input logic             keyDone,
  input logic             enabled,
  input logic             cntAtMax,
  input logic [CNT_W-1:0] cnt,
  input logic             rstOut
);

  logic [15:0] hiLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       hiLen <= '0;
    else if (rstOut) hiLen <= hiLen + 16'd1;
    else             hiLen <= '0;
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    enabled && mcStrobe && !keyDone && !cntAtMax |=> cnt == $past(cnt) + CNT_W'(1));

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    enabled && !mcStrobe && !keyDone && !cntAtMax |=> $stable(cnt));

  assert_key_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    keyDone |=> enabled && cnt == '0);

  assert_overflow_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    enabled && cntAtMax |=> rstOut && !enabled);

  assert_stop_only_by_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enabled) |-> rstOut);

  assert_dormant_in_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstOut |-> !enabled && !keyDone);

  assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstOut |-> hiLen < 16'(PULSE_LONG));

  assert_pulse_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOut) |-> (hiLen == 16'(PULSE_SHORT) || hiLen == 16'(PULSE_LONG)));

endmodule

bind wdog_top wdog_chk #(
  .CNT_W(CNT_W), .PULSE_SHORT(PULSE_SHORT), .PULSE_LONG(PULSE_LONG)
) u_chk (
  .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .keyDone(keyDone),
  .enabled(enabled), .cntAtMax(cntAtMax), .cnt(cntVal), .rstOut(rstOut)
);

// File: tb/sim_wdog_top.sv
module sim_wdog_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mcStrobe = 1'b1;
  logic       modeSix = 1'b1;
  logic       sfrWrEn = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic [7:0] sfrData = 8'h00;
  logic       rstOut;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wdog_top u0 (
    .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .modeSix(modeSix),
    .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr), .sfrData(sfrData), .rstOut(rstOut)
  );

  typedef struct packed {
    logic [7:0]  a0, d0, a1, d1, a2, d2;
    logic        six;
    logic [15:0] lat;   // negedges after last write until rstOut high, 0 = none
    logic [7:0]  plen;
  } vecT;

  localparam vecT VECS [4] = '{
    '{8'hA6, 8'h1E, 8'hA6, 8'hE1, 8'hA0, 8'h00, 1'b1, 16'd16383, 8'd98},   // R2 R7
    '{8'hA6, 8'h1E, 8'hA5, 8'hE1, 8'hA6, 8'hE1, 1'b0, 16'd16384, 8'd196},  // R2 R7
    '{8'hA6, 8'h1E, 8'hA6, 8'h55, 8'hA6, 8'hE1, 1'b1, 16'd0,     8'd0},    // R3
    '{8'hA6, 8'h1E, 8'hA6, 8'h1E, 8'hA6, 8'hE1, 1'b1, 16'd16384, 8'd98}    // R3 R4
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfrWrEn = 1'b1; sfrAddr = a; sfrData = d;
    @(negedge clk);
    sfrWrEn = 1'b0;
  endtask

  // waits up to n negedges, returns index of first negedge with rstOut high
  task automatic idle(input int n, output int firstHi);
    firstHi = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (rstOut) begin
        firstHi = i;
        break;
      end
    end
  endtask

  task automatic width(inout int w);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rstOut) w++;
      else break;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hi, hi2, w;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(rstOut == 1'b0, "R1 rstOut in reset", rstOut, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(rstOut == 1'b0, "R1 rstOut after reset", rstOut, 0);

    // table walk
    for (int v = 0; v < 4; v++) begin
      modeSix = VECS[v].six;
      wr(VECS[v].a0, VECS[v].d0);
      wr(VECS[v].a1, VECS[v].d1);
      wr(VECS[v].a2, VECS[v].d2);
      if (VECS[v].lat == 0) begin
        idle(16500, hi);
        check(hi == 0, "R3 broken key must not start timer", hi, 0);
      end else begin
        idle(int'(VECS[v].lat) + 20, hi);
        check(hi == int'(VECS[v].lat), "R2 R4 latency to rstOut", hi, int'(VECS[v].lat));
        w = 1;
        width(w);
        check(w == int'(VECS[v].plen), "R7 pulse width", w, int'(VECS[v].plen));
      end
      repeat (2) @(negedge clk);
    end

    // service one edge before overflow, with strobe gap and stray writes
    modeSix = 1'b1;
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    mcStrobe = 1'b0;
    wr(8'hA6, 8'h00);
    wr(8'hA6, 8'hE1);
    idle(98, hi);
    mcStrobe = 1'b1;
    idle(16381, hi2);
    check(hi == 0 && hi2 == 0, "R4 R2 no early pulse with strobe gap", hi + hi2, 0);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    idle(16400, hi);
    check(hi == 16384, "R5 service at 3FFEH restarts count", hi, 16384);
    repeat (10) @(negedge clk);
    check(rstOut == 1'b1, "R7 pulse still active", rstOut, 1);
    rstN = 1'b0;
    #1;
    check(rstOut == 1'b0, "R9 reset kills pulse", rstOut, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(rstOut == 1'b0, "R9 R1 low after reset release", rstOut, 0);

    // service on the overflow edge
    modeSix = 1'b0;
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    idle(16382, hi);
    check(hi == 0, "R4 no pulse before overflow", hi, 0);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    check(rstOut == 1'b1, "R6 overflow wins over service", rstOut, 1);
    w = 1;
    wr(8'hA6, 8'h1E);
    if (rstOut) w++;
    wr(8'hA6, 8'hE1);
    if (rstOut) w++;
    width(w);
    check(w == 196, "R7 R8 long pulse with writes inside", w, 196);
    idle(16500, hi);
    check(hi == 0, "R8 dormant after pulse", hi, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule